// File: doc/BRIEF.md
# Positive-Comma Serial Word Aligner

This block sits behind a clock-recovery front end. It takes a retimed serial stream, one bit per clock, and rebuilds 10-bit code groups from it. Serialization loses the code-group boundary, so the block finds it again. It searches the stream for the seven-bit comma 0011111, in the first-received-bit-first order, and moves the word boundary so that a comma always opens an output word. Only this one comma polarity is recognised. Its inverse, 1100000, which the other running disparity produces, is ignored. As a result the block may see a comma in only every second K character, and it must still lock.

Every clock the block keeps a 20-bit history window. At each word strobe it checks all ten candidate bit offsets of the window for the comma. The output word is taken from the window at the selected offset. The word counter is never restarted, so the strobe fires exactly once every ten clocks and no output cycle is stretched or shortened by a realignment. A three-state lock machine tracks the alignment. ST_HUNT means no comma has been seen since reset. ST_VERIFY means one comma offset is held but not yet confirmed. ST_LOCKED means the offset has been confirmed. Its transitions are:
- HUNT_TO_VERIFY: the first comma is seen.
- VERIFY_CONFIRM: a comma is seen again at the held offset, moving to ST_LOCKED.
- VERIFY_RELOAD: a comma is seen at another offset, staying in ST_VERIFY with the new offset.
- LOCKED_HOLD: a comma is seen at the held offset.
- LOCKED_SLIP: a comma is seen at a different offset, moving to ST_VERIFY with the new offset.

Top module: `comma_word_aligner`

## Requirements
- R1: A synchronous active-high reset clears the history and the output word to zero, sets the offset to zero, enters ST_HUNT, and holds word_stb, comma_seen and aligned low.
- R2: After reset is released, word_stb is high for exactly one cycle in every ten. The first pulse follows the tenth clock edge after reset. word_out changes only together with word_stb.
- R3: Until the first comma is detected, word n (counted from 0) holds received bits 10n to 10n+9. The first bit received after reset is at word_out[0], and later bits sit at higher indices.
- R4: A comma 0011111 starting at any of the ten bit positions is detected. The word strobed with its detection begins at the comma, so word_out[6:0] equals 7'b1111100.
- R5: The inverted pattern 1100000 never causes a detection, never changes the offset, and never changes the aligned flag.
- R6: comma_seen is high exactly in the cycles where word_stb carries a word that begins with a detected comma.
- R7: After the offset changes, every later word is the ten bits that directly follow the previous word's comma-aligned boundary. The strobe period does not change.
- R8: aligned rises together with the strobe of the second comma detected at the same offset, with no comma at another offset in between. Commas in only every second K character are enough.
- R9: A comma at an offset different from the held one drops aligned in that same strobe cycle and loads the new offset. aligned rises again on the next comma at that new offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock from the recovery front end |
| rst | input | 1 | Synchronous active-high reset |
| ser_bit | input | 1 | Retimed serial data, one bit per clock |
| word_out | output | 10 | Parallel code group; bit 0 is the earliest received bit |
| word_stb | output | 1 | One-cycle strobe marking a new word_out, every ten clocks |
| comma_seen | output | 1 | Set with the strobe of a word that begins with a comma |
| aligned | output | 1 | Boundary confirmed by two commas at the same offset |

## Verification
The hardest case to reach from the ports is a slip while locked. Here a comma arrives at a new bit offset after the block has confirmed an old one. The state must fall back and the strobe must keep its fixed ten-clock rhythm. The stimulus reaches it by building streams from known code groups. It first locks at a start shift swept over all ten values. It then inserts one to nine extra filler bits before the next commas, and it repeats this for every combination of start shift and slip distance. Streams that alternate positive and negative comma characters exercise the every-second-K case. A stream made only of negative commas shows that the inverse pattern is ignored.

// File: rtl/cwa_pkg.sv
package cwa_pkg;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } lock_state_t;

endpackage

// File: rtl/cwa_history.sv
// Serial history window; win[0] is the bit on the input in this cycle,
// win[i] is the bit received i cycles earlier.
module cwa_history #(
    parameter int WIN_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_bit,
    output logic [WIN_W-1:0] win
);

    logic [WIN_W-2:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else begin
            hist_q <= {hist_q[WIN_W-3:0], ser_bit};
        end
    end

    assign win = {hist_q, ser_bit};

endmodule

// File: rtl/cwa_phase.sv
// Free-running word phase counter; never reloaded by alignment.
module cwa_phase #(
    parameter int WORD_W = 10,
    parameter int CNT_W  = 4
) (
    input  logic clk,
    input  logic rst,
    output logic strobe_now
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign strobe_now = (cnt_q == LAST);

endmodule

// File: rtl/cwa_comma_scan.sv
// Checks the comma at every candidate word offset of the window.
// Offset k word bit j lives at win[WORD_W-1+k-j].
module cwa_comma_scan #(
    parameter int                WORD_W    = 10,
    parameter int                COMMA_W   = 7,
    parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100,
    parameter int                WIN_W     = 20,
    parameter int                OFF_W     = 4
) (
    input  logic [WIN_W-1:0] win,
    output logic             found,
    output logic [OFF_W-1:0] hit_idx
);

    logic [WORD_W-1:0] hit;

    for (genvar k = 0; k < WORD_W; k++) begin : g_off
        logic [COMMA_W-1:0] cand;
        for (genvar j = 0; j < COMMA_W; j++) begin : g_bit
            assign cand[j] = win[WORD_W-1+k-j];
        end
        assign hit[k] = (cand == COMMA_PAT);
    end

    always_comb begin
        hit_idx = '0;
        for (int k = WORD_W - 1; k >= 0; k--) begin
            if (hit[k]) begin
                hit_idx = OFF_W'(k);
            end
        end
    end

    assign found = |hit;

endmodule

// File: rtl/cwa_word_mux.sv
// Selects the 10-bit word at a given offset out of the history window.
module cwa_word_mux #(
    parameter int WORD_W = 10,
    parameter int WIN_W  = 20,
    parameter int OFF_W  = 4
) (
    input  logic [WIN_W-1:0]  win,
    input  logic [OFF_W-1:0]  off,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] cands [WORD_W];

    for (genvar k = 0; k < WORD_W; k++) begin : g_off
        for (genvar j = 0; j < WORD_W; j++) begin : g_bit
            assign cands[k][j] = win[WORD_W-1+k-j];
        end
    end

    always_comb begin
        word = cands[0];
        for (int k = 0; k < WORD_W; k++) begin
            if (off == OFF_W'(k)) begin
                word = cands[k];
            end
        end
    end

endmodule

// File: rtl/cwa_lock_fsm.sv
// Alignment lock machine: holds the boundary offset and the aligned flag.
module cwa_lock_fsm
    import cwa_pkg::*;
#(
    parameter int OFF_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe_now,
    input  logic             found,
    input  logic [OFF_W-1:0] hit_idx,
    output logic [OFF_W-1:0] off_use,
    output logic             aligned_q
);

    lock_state_t      st_q, st_d;
    logic [OFF_W-1:0] off_q, off_d;
    logic             detect;

    assign detect = strobe_now && found;

    // state and offset register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_HUNT;
            off_q <= '0;
        end else begin
            st_q  <= st_d;
            off_q <= off_d;
        end
    end

    // transitions
    always_comb begin
        st_d  = st_q;
        off_d = off_q;
        if (detect) begin
            unique case (st_q)
                ST_HUNT: begin                      // HUNT_TO_VERIFY
                    st_d  = ST_VERIFY;
                    off_d = hit_idx;
                end
                ST_VERIFY: begin
                    if (hit_idx == off_q) begin     // VERIFY_CONFIRM
                        st_d = ST_LOCKED;
                    end else begin                  // VERIFY_RELOAD
                        off_d = hit_idx;
                    end
                end
                ST_LOCKED: begin
                    if (hit_idx != off_q) begin     // LOCKED_SLIP
                        st_d  = ST_VERIFY;
                        off_d = hit_idx;
                    end                             // else LOCKED_HOLD
                end
                default: begin
                    st_d  = ST_HUNT;
                    off_d = '0;
                end
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            aligned_q <= 1'b0;
        end else begin
            aligned_q <= (st_d == ST_LOCKED);
        end
    end

    assign off_use = detect ? hit_idx : off_q;

endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner #(
    parameter int                 WORD_W    = 10,
    parameter int                 COMMA_W   = 7,
    parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_bit,
    output logic [WORD_W-1:0] word_out,
    output logic              word_stb,
    output logic              comma_seen,
    output logic              aligned
);

    localparam int WIN_W = 2 * WORD_W;
    localparam int OFF_W = $clog2(WORD_W);

    logic [WIN_W-1:0]  win;
    logic              strobe_now;
    logic              found;
    logic [OFF_W-1:0]  hit_idx;
    logic [OFF_W-1:0]  off_use;
    logic [WORD_W-1:0] sel_word;

    cwa_history #(.WIN_W(WIN_W)) u_hist (
        .clk     (clk),
        .rst     (rst),
        .ser_bit (ser_bit),
        .win     (win)
    );

    cwa_phase #(.WORD_W(WORD_W), .CNT_W(OFF_W)) u_phase (
        .clk        (clk),
        .rst        (rst),
        .strobe_now (strobe_now)
    );

    cwa_comma_scan #(
        .WORD_W    (WORD_W),
        .COMMA_W   (COMMA_W),
        .COMMA_PAT (COMMA_PAT),
        .WIN_W     (WIN_W),
        .OFF_W     (OFF_W)
    ) u_scan (
        .win     (win),
        .found   (found),
        .hit_idx (hit_idx)
    );

    cwa_lock_fsm #(.OFF_W(OFF_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .strobe_now (strobe_now),
        .found      (found),
        .hit_idx    (hit_idx),
        .off_use    (off_use),
        .aligned_q  (aligned)
    );

    cwa_word_mux #(.WORD_W(WORD_W), .WIN_W(WIN_W), .OFF_W(OFF_W)) u_mux (
        .win  (win),
        .off  (off_use),
        .word (sel_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_out   <= '0;
            word_stb   <= 1'b0;
            comma_seen <= 1'b0;
        end else begin
            word_stb   <= strobe_now;
            comma_seen <= strobe_now && found;
            if (strobe_now) begin
                word_out <= sel_word;
            end
        end
    end

endmodule

// File: rtl/cwa_checker.sv
module cwa_checker #(
    parameter int                 WORD_W    = 10,
    parameter int                 COMMA_W   = 7,
    parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] word_out,
    input logic              word_stb,
    input logic              comma_seen,
    input logic              aligned
);

    localparam int PH_W = $clog2(WORD_W);

    logic [PH_W-1:0] ph_q;
    logic            run_q;
    logic            warm_q;
    logic            was_rst_q;

    always_ff @(posedge clk) begin
        was_rst_q <= rst;
        if (rst) begin
            ph_q   <= '0;
            run_q  <= 1'b0;
            warm_q <= 1'b0;
        end else begin
            warm_q <= 1'b1;
            if (ph_q == PH_W'(WORD_W - 1)) begin
                ph_q  <= '0;
                run_q <= 1'b1;
            end else begin
                ph_q <= ph_q + 1'b1;
            end
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        was_rst_q |-> (!word_stb && !comma_seen && !aligned && word_out == '0));

    assert_strobe_period_R2: assert property (@(posedge clk) disable iff (rst)
        word_stb == (run_q && ph_q == '0));

    assert_word_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (warm_q && !word_stb) |-> $stable(word_out));

    assert_comma_word_R4: assert property (@(posedge clk) disable iff (rst)
        comma_seen |-> (word_out[COMMA_W-1:0] == COMMA_PAT));

    assert_comma_with_stb_R6: assert property (@(posedge clk) disable iff (rst)
        comma_seen |-> word_stb);

    assert_align_rise_R8: assert property (@(posedge clk) disable iff (rst)
        (warm_q && $rose(aligned)) |-> comma_seen);

    assert_align_fall_R9: assert property (@(posedge clk) disable iff (rst)
        (warm_q && $fell(aligned)) |-> comma_seen);

    assert_align_steady_R5: assert property (@(posedge clk) disable iff (rst)
        (warm_q && !comma_seen) |-> $stable(aligned));

endmodule

bind comma_word_aligner cwa_checker #(
    .WORD_W    (WORD_W),
    .COMMA_W   (COMMA_W),
    .COMMA_PAT (COMMA_PAT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .word_out   (word_out),
    .word_stb   (word_stb),
    .comma_seen (comma_seen),
    .aligned    (aligned)
);

// File: tb/sim_comma_word_aligner.sv
`timescale 1ns/1ps
module sim_comma_word_aligner;

    localparam int MAXN = 400;
    // code groups, bit 0 transmitted first
    localparam logic [9:0] KPOS = 10'b0101111100; // carries 0011111
    localparam logic [9:0] KNEG = 10'b1010000011; // carries 1100000
    localparam logic [9:0] FILL = 10'b0101010101;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_bit = 1'b0;
    logic [9:0] word_out;
    logic       word_stb;
    logic       comma_seen;
    logic       aligned;

    int total = 0;
    int bad   = 0;

    bit bits   [0:MAXN-1];
    bit cstart [0:MAXN-1];
    int len;

    int         m_state;
    int         m_off;
    logic [9:0] last_word;
    bit         any_comma;
    bit         slip_seen;
    bit         saw_cs;
    string      tag_pre;

    always #2.5 clk = ~clk;

    comma_word_aligner u0 (
        .clk        (clk),
        .rst        (rst),
        .ser_bit    (ser_bit),
        .word_out   (word_out),
        .word_stb   (word_stb),
        .comma_seen (comma_seen),
        .aligned    (aligned)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clr();
        len = 0;
    endtask

    task automatic push_bit(input bit b);
        bits[len]   = b;
        cstart[len] = 1'b0;
        len++;
    endtask

    task automatic push_char(input logic [9:0] c, input bit is_comma);
        int p0;
        p0 = len;
        for (int j = 0; j < 10; j++) push_bit(c[j]);
        cstart[p0] = is_comma;
    endtask

    task automatic push_junk(input int n);
        for (int i = 0; i < n; i++) push_bit(~i[0]);
    endtask

    task automatic check_edge(input int e);
        bit         sexp;
        bit         cs;
        int         p;
        int         k;
        int         idx;
        logic [9:0] w;
        string      tag;
        sexp = ((e % 10) == 9);
        chk(word_stb == sexp, "R2", int'(word_stb), int'(sexp));
        if (sexp) begin
            p  = -1;
            cs = 1'b0;
            for (int q = e - 18; q <= e - 9; q++) begin
                if (q >= 0 && cstart[q]) p = q;
            end
            if (p >= 0) begin
                cs = 1'b1;
                k  = e - 9 - p;
                case (m_state)
                    0: begin m_state = 1; m_off = k; end
                    1: begin
                        if (k == m_off) m_state = 2;
                        else m_off = k;
                    end
                    default: begin
                        if (k != m_off) begin
                            m_state = 1; m_off = k; slip_seen = 1'b1;
                        end
                    end
                endcase
            end else begin
                k = m_off;
            end
            for (int j = 0; j < 10; j++) begin
                idx  = e - 9 - k + j;
                w[j] = (idx >= 0) ? bits[idx] : 1'b0;
            end
            tag = cs ? "R4" : (any_comma ? "R7" : tag_pre);
            chk(word_out == w, tag, int'(word_out), int'(w));
            chk(comma_seen == cs, "R6", int'(comma_seen), int'(cs));
            if (cs) any_comma = 1'b1;
            last_word = w;
        end else begin
            chk(word_out == last_word, "R2", int'(word_out), int'(last_word));
            chk(comma_seen == 1'b0, "R6", int'(comma_seen), 0);
        end
        if (comma_seen) saw_cs = 1'b1;
        chk(aligned == (m_state == 2), slip_seen ? "R9" : "R8",
            int'(aligned), int'(m_state == 2));
    endtask

    task automatic run_stream(input string pre);
        m_state   = 0;
        m_off     = 0;
        last_word = '0;
        any_comma = 1'b0;
        slip_seen = 1'b0;
        saw_cs    = 1'b0;
        tag_pre   = pre;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(word_out == '0, "R1", int'(word_out), 0);
        chk(!word_stb && !comma_seen && !aligned, "R1",
            int'({word_stb, comma_seen, aligned}), 0);
        rst     = 1'b0;
        ser_bit = bits[0];
        for (int n = 0; n < len; n++) begin
            @(negedge clk);
            check_edge(n);
            if (n + 1 < len) ser_bit = bits[n + 1];
        end
    endtask

    initial begin
        // lock sweep over every start shift, commas in every second K char
        for (int s = 0; s < 10; s++) begin
            clr();
            push_junk(s);
            push_char(FILL, 0); push_char(KPOS, 1); push_char(FILL, 0);
            push_char(KNEG, 0); push_char(FILL, 0); push_char(KPOS, 1);
            push_char(FILL, 0); push_char(KNEG, 0); push_char(KPOS, 1);
            push_char(FILL, 0); push_char(FILL, 0); push_char(FILL, 0);
            run_stream("R3");
            chk(saw_cs == 1'b1, "R4", int'(saw_cs), 1);
        end
        // slip sweep: lock at s1, then shift the boundary by d bits
        for (int s1 = 0; s1 < 10; s1++) begin
            for (int d = 1; d < 10; d++) begin
                clr();
                push_junk(s1);
                push_char(FILL, 0); push_char(KPOS, 1); push_char(FILL, 0);
                push_char(KPOS, 1); push_char(FILL, 0);
                push_junk(d);
                push_char(FILL, 0); push_char(KPOS, 1); push_char(FILL, 0);
                push_char(KNEG, 0); push_char(KPOS, 1); push_char(FILL, 0);
                push_char(FILL, 0); push_char(FILL, 0);
                run_stream("R3");
                chk(slip_seen == 1'b1, "R9", int'(slip_seen), 1);
            end
        end
        // negative commas only: never detected
        for (int s = 0; s < 10; s += 3) begin
            clr();
            push_junk(s);
            for (int i = 0; i < 6; i++) begin
                push_char(FILL, 0); push_char(KNEG, 0);
            end
            push_char(FILL, 0);
            run_stream("R5");
            chk(saw_cs == 1'b0, "R5", int'(saw_cs), 0);
            chk(aligned == 1'b0, "R5", int'(aligned), 0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule